// File: doc/BRIEF.md
# Dual-slot transmit frame queue

This block is the transmit-side front end of a simple Ethernet MAC. Software programs a frame by writing the frame's start address into an address register and then its byte count into a length register. The length write is the commit. The block holds at most two frames: one running and one waiting. It reads the frame bytes through a synchronous, byte-wide memory read port and presents them one per cycle on a byte stream that carries a last-byte marker.

Live status outputs report whether another frame can be queued and whether the transmitter has gone fully quiet. Sticky bits record that a frame has completed and that a queue attempt was dropped. Both sticky bits clear when ones are written to them. A completion interrupt pulse is gated by an enable bit, which has separate set and clear registers. A global transmit-enable bit starts and stops the whole queue. Preamble, FCS, collisions and the PHY belong to other blocks.

Top module: `txq_tx_front`

## Requirements
- R1: After reset, the transmit enable and the interrupt enable are 0. No read is issued and no byte is presented. The room and idle bits are 1, and the done bit, the overflow bit and the interrupt are 0.
- R2: Writing a non-zero length while enabled commits a frame that starts at the last value written to the address register. One read per cycle is issued at consecutive addresses. Each byte appears on the stream one cycle after its read, and the marker is on the final byte only.
- R3: The room bit is 0 exactly while one frame is running and another is waiting. A commit is dropped, and the sticky overflow bit (status bit 1) is set, only if both slots are still occupied after any frame that retires in that same cycle.
- R4: When the running frame issues its final read while a frame is waiting, the waiting frame's first read is issued on the next cycle, and the room bit is 1 in that cycle.
- R5: The idle bit is 1 exactly when no frame is running, none is waiting and no fetched byte is still due on the stream.
- R6: A length write of zero is ignored. Nothing is queued, no read is issued and the overflow bit is unchanged.
- R7: The sticky done bit (status bit 0) sets one cycle after a final byte appears on the stream. If the interrupt enable is 1, the interrupt pulses high in that same cycle. Writing 1 to bit 0 of the enable-set register sets the interrupt enable, and writing 1 to bit 0 of the enable-clear register clears it.
- R8: Writing a 1 to a bit of the status register clears that sticky bit. A set event in the same cycle wins over the clear.
- R9: Clearing the transmit enable (bit 0 of the control register) discards both slots and stops reads. Length writes made while disabled are ignored.
- R10: The register offsets are: control 0, address 1, length 2, status 3, interrupt enable set 4, interrupt enable clear 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | max(ADDR_W,LEN_W) | Register write data |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| st_room | output | 1 | Queue can accept a frame |
| st_idle | output | 1 | Nothing running, waiting or in flight |
| st_done | output | 1 | Sticky frame-complete status |
| st_ovf | output | 1 | Sticky dropped-commit status |
| st_ien | output | 1 | Interrupt enable state |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The critical coincidence is a length commit that lands in the same cycle as the running frame's final read while the second slot is full. The retirement frees a slot just in time, so the commit must be accepted, not counted as an overflow. The bench provokes this by placing the third length write exactly on the first frame's last read cycle. It judges the outcome by checking that the overflow bit stays clear and that the third frame streams right after the second. A second coincidence, a status clear arriving together with a new completion, is timed the same way and must leave the done bit set.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_QADDR = 3'd1,
      REG_QLEN  = 3'd2,
      REG_STAT  = 3'd3,
      REG_IEN   = 3'd4,
      REG_IDIS  = 3'd5
   } txq_reg_e;

   localparam int unsigned BIT_EN   = 0;
   localparam int unsigned BIT_DONE = 0;
   localparam int unsigned BIT_OVF  = 1;
endpackage

// File: rtl/txq_regs.sv
module txq_regs
   import txq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LEN_W   = 11,
   parameter int unsigned WD_W    = 16,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [WD_W-1:0]   wr_data,
   input  logic              done_evt,
   input  logic              ovf_evt,
   output logic              en,
   output logic [ADDR_W-1:0] q_addr,
   output logic              commit,
   output logic [LEN_W-1:0]  cm_len,
   output logic              st_done,
   output logic              st_ovf,
   output logic              ien,
   output logic              irq
);
   logic en_q, ien_q, done_q, ovf_q;
   logic [ADDR_W-1:0] qaddr_q;
   logic clr_done, clr_ovf, hit_stat;

   generate
      if (WD_W < ADDR_W || WD_W < LEN_W) begin : g_bad_width
         $error("txq_regs: write data narrower than a field");
      end
   endgenerate

   assign hit_stat = wr_en && (wr_addr == REG_STAT);
   assign clr_done = hit_stat && wr_data[BIT_DONE];
   assign clr_ovf  = hit_stat && wr_data[BIT_OVF];
   assign cm_len   = wr_data[LEN_W-1:0];
   assign commit   = en_q && wr_en && (wr_addr == REG_QLEN) && (cm_len != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         ien_q   <= 1'b0;
         done_q  <= 1'b0;
         ovf_q   <= 1'b0;
         qaddr_q <= '0;
      end else begin
         if (wr_en && wr_addr == REG_CTRL)  en_q    <= wr_data[BIT_EN];
         if (wr_en && wr_addr == REG_QADDR) qaddr_q <= wr_data[ADDR_W-1:0];
         if (wr_en && wr_addr == REG_IEN && wr_data[0])  ien_q <= 1'b1;
         if (wr_en && wr_addr == REG_IDIS && wr_data[0]) ien_q <= 1'b0;
         done_q <= done_evt | (done_q & ~clr_done);
         ovf_q  <= ovf_evt  | (ovf_q  & ~clr_ovf);
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= done_evt & ien_q;
         end
         assign irq = irq_q;

         p_irq_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> st_done);
      end else begin : g_irq_comb
         assign irq = done_evt & ien_q;
      end
   endgenerate

   assign en      = en_q;
   assign ien     = ien_q;
   assign q_addr  = qaddr_q;
   assign st_done = done_q;
   assign st_ovf  = ovf_q;

   p_w1c_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_done && !done_evt) |=> !st_done);
   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_ovf && !hit_stat) |=> st_ovf);
endmodule

// File: rtl/txq_slots.sv
module txq_slots #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned LEN_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              commit,
   input  logic [ADDR_W-1:0] cm_addr,
   input  logic [LEN_W-1:0]  cm_len,
   input  logic              issue,
   output logic              act_valid,
   output logic [ADDR_W-1:0] act_ptr,
   output logic              act_last,
   output logic              wait_valid,
   output logic              ovf_evt
);
   typedef struct packed {
      logic [ADDR_W-1:0] ptr;
      logic [LEN_W-1:0]  rem;
   } slot_t;

   slot_t act_q, wait_q, act_n, wait_n;
   logic  act_v_q, wait_v_q, act_v_n, wait_v_n, ovf_c;

   assign act_last = (act_q.rem == LEN_W'(1));

   always_comb begin
      act_n    = act_q;
      wait_n   = wait_q;
      act_v_n  = act_v_q;
      wait_v_n = wait_v_q;
      ovf_c    = 1'b0;
      if (issue) begin
         act_n.ptr = act_q.ptr + ADDR_W'(1);
         act_n.rem = act_q.rem - LEN_W'(1);
         if (act_last) act_v_n = 1'b0;
      end
      if (!act_v_n && wait_v_n) begin
         act_n    = wait_q;
         act_v_n  = 1'b1;
         wait_v_n = 1'b0;
      end
      if (commit) begin
         if (!act_v_n) begin
            act_n   = '{ptr: cm_addr, rem: cm_len};
            act_v_n = 1'b1;
         end else if (!wait_v_n) begin
            wait_n   = '{ptr: cm_addr, rem: cm_len};
            wait_v_n = 1'b1;
         end else begin
            ovf_c = 1'b1;
         end
      end
      if (!en) begin
         act_v_n  = 1'b0;
         wait_v_n = 1'b0;
         ovf_c    = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= '0;
         wait_q   <= '0;
         act_v_q  <= 1'b0;
         wait_v_q <= 1'b0;
      end else begin
         act_q    <= act_n;
         wait_q   <= wait_n;
         act_v_q  <= act_v_n;
         wait_v_q <= wait_v_n;
      end
   end

   assign act_valid  = act_v_q;
   assign act_ptr    = act_q.ptr;
   assign wait_valid = wait_v_q;
   assign ovf_evt    = ovf_c;

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |-> (act_valid && wait_valid));
   p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && act_last && wait_valid && !commit) |=> (act_valid && !wait_valid));
   p_rem_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> (act_q.rem != '0));
   p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!act_valid && !wait_valid));
endmodule

// File: rtl/txq_fetch.sv
module txq_fetch #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              act_valid,
   input  logic [ADDR_W-1:0] act_ptr,
   input  logic              act_last,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              issue,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_last,
   output logic              in_flight,
   output logic              done_evt
);
   logic rd_pend_q, rd_last_q;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("txq_fetch: stream must be byte wide");
      end
   endgenerate

   assign issue     = en && act_valid;
   assign mem_rd_en = issue;
   assign mem_addr  = act_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend_q <= 1'b0;
         rd_last_q <= 1'b0;
      end else begin
         rd_pend_q <= issue;
         rd_last_q <= issue && act_last;
      end
   end

   assign tx_valid  = rd_pend_q;
   assign tx_last   = rd_pend_q && rd_last_q;
   assign tx_data   = rd_pend_q ? mem_rdata : '0;
   assign in_flight = rd_pend_q;
   assign done_evt  = rd_pend_q && rd_last_q;

   p_addr_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !act_last) |=> (!mem_rd_en || mem_addr == $past(mem_addr) + ADDR_W'(1)));
   p_byte_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> tx_valid);
endmodule

// File: rtl/txq_tx_front.sv
module txq_tx_front #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LEN_W   = 11,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          reg_wr_en,
   input  logic [2:0]                                    reg_addr,
   input  logic [((ADDR_W > LEN_W) ? ADDR_W : LEN_W)-1:0] reg_wdata,
   output logic                                          mem_rd_en,
   output logic [ADDR_W-1:0]                             mem_addr,
   input  logic [7:0]                                    mem_rdata,
   output logic                                          tx_valid,
   output logic [7:0]                                    tx_data,
   output logic                                          tx_last,
   output logic                                          st_room,
   output logic                                          st_idle,
   output logic                                          st_done,
   output logic                                          st_ovf,
   output logic                                          st_ien,
   output logic                                          irq
);
   localparam int unsigned WD_W = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;

   logic              en, commit, issue, act_valid, act_last, wait_valid;
   logic              ovf_evt, done_evt, in_flight;
   logic [ADDR_W-1:0] q_addr, act_ptr;
   logic [LEN_W-1:0]  cm_len;

   txq_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WD_W(WD_W), .IRQ_REG(IRQ_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .done_evt(done_evt), .ovf_evt(ovf_evt), .en(en), .q_addr(q_addr), .commit(commit),
      .cm_len(cm_len), .st_done(st_done), .st_ovf(st_ovf), .ien(st_ien), .irq(irq)
   );

   txq_slots #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_slots (
      .clk(clk), .rst_n(rst_n), .en(en), .commit(commit), .cm_addr(q_addr), .cm_len(cm_len),
      .issue(issue), .act_valid(act_valid), .act_ptr(act_ptr), .act_last(act_last),
      .wait_valid(wait_valid), .ovf_evt(ovf_evt)
   );

   txq_fetch #(.ADDR_W(ADDR_W), .BYTE_W(8)) u_fetch (
      .clk(clk), .rst_n(rst_n), .en(en), .act_valid(act_valid), .act_ptr(act_ptr),
      .act_last(act_last), .mem_rdata(mem_rdata), .issue(issue), .mem_rd_en(mem_rd_en),
      .mem_addr(mem_addr), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .in_flight(in_flight), .done_evt(done_evt)
   );

   assign st_room = !wait_valid;
   assign st_idle = !act_valid && !wait_valid && !in_flight;

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st_idle |=> !tx_valid);
   p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |=> st_done);
endmodule

// File: tb/txq_tx_front_test.sv
module txq_tx_front_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int LW = 11;
   localparam int A_CTRL = 0, A_QADDR = 1, A_QLEN = 2, A_STAT = 3, A_IEN = 4, A_IDIS = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wa = '0;
   logic [15:0] wd = '0;
   logic mem_rd_en, tx_valid, tx_last, st_room, st_idle, st_done, st_ovf, st_ien, irq;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_rdata = '0;
   logic [7:0] tx_data;

   int checks = 0, fails = 0, cyc = 0, irq_cnt = 0;
   bit started = 1'b0, ended = 1'b0;
   string cur_tag = "R1";

   // reference model state
   int fa[$], fl[$];
   int h_ptr, h_rem, p_addr, m_qaddr;
   bit m_en, m_ie, m_done, m_ovf, m_irq, p_v, p_last;
   bit iss, fin, dev, oev, cm;
   int n_pa;
   bit n_pv, n_pl;

   txq_tx_front uut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(wa), .reg_wdata(wd),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .st_room(st_room),
      .st_idle(st_idle), .st_done(st_done), .st_ovf(st_ovf), .st_ien(st_ien), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] memf(int a);
      return 8'((a * 37) + 11);
   endfunction

   always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(int'(mem_addr));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s (%s) actual=%0d expected=%0d", req, what, cur_tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // behavioural reference, one step per clock
   always @(posedge clk) begin
      if (!rst_n) begin
         fa.delete(); fl.delete();
         h_ptr = 0; h_rem = 0; p_addr = 0; m_qaddr = 0;
         m_en = 0; m_ie = 0; m_done = 0; m_ovf = 0; m_irq = 0; p_v = 0; p_last = 0;
      end else begin
         iss = m_en && (fa.size() > 0);
         fin = iss && (h_rem == 1);
         dev = p_v && p_last;
         n_pv = iss; n_pl = fin; n_pa = h_ptr;
         if (iss) begin
            h_ptr++; h_rem--;
            if (fin) begin
               void'(fa.pop_front()); void'(fl.pop_front());
               if (fa.size() > 0) begin h_ptr = fa[0]; h_rem = fl[0]; end
            end
         end
         cm = wr_en && (int'(wa) == A_QLEN) && (wd[LW-1:0] != 0) && m_en;
         oev = 0;
         if (!m_en) begin
            fa.delete(); fl.delete();
         end else if (cm) begin
            if (fa.size() < 2) begin
               fa.push_back(m_qaddr); fl.push_back(int'(wd[LW-1:0]));
               if (fa.size() == 1) begin h_ptr = m_qaddr; h_rem = int'(wd[LW-1:0]); end
            end else oev = 1;
         end
         m_irq = dev && m_ie;
         m_done = dev || (m_done && !(wr_en && int'(wa) == A_STAT && wd[0]));
         m_ovf  = oev || (m_ovf && !(wr_en && int'(wa) == A_STAT && wd[1]));
         if (wr_en && int'(wa) == A_CTRL)  m_en = wd[0];
         if (wr_en && int'(wa) == A_QADDR) m_qaddr = int'(wd);
         if (wr_en && int'(wa) == A_IEN && wd[0])  m_ie = 1;
         if (wr_en && int'(wa) == A_IDIS && wd[0]) m_ie = 0;
         p_v = n_pv; p_last = n_pl; p_addr = n_pa;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         chk("R2", "tx_valid", int'(tx_valid), int'(p_v));
         if (p_v) chk("R2", "tx_data", int'(tx_data), int'(memf(p_addr)));
         chk("R2", "tx_last", int'(tx_last), int'(p_v && p_last));
         chk("R4", "mem_rd_en", int'(mem_rd_en), int'(m_en && fa.size() > 0));
         if (m_en && fa.size() > 0) chk("R2", "mem_addr", int'(mem_addr), h_ptr & 16'hFFFF);
         chk("R3", "room", int'(st_room), int'(fa.size() < 2));
         chk("R5", "idle", int'(st_idle), int'(fa.size() == 0 && !p_v));
         chk("R7", "done", int'(st_done), int'(m_done));
         chk("R3", "ovf", int'(st_ovf), int'(m_ovf));
         chk("R7", "ien", int'(st_ien), int'(m_ie));
         chk("R7", "irq", int'(irq), int'(m_irq));
      end
   end

   always @(posedge clk) begin
      if (irq) irq_cnt++;
      cyc++;
      if (cyc > 5000) begin
         fails++;
         $display("FAIL watchdog expired (%s)", cur_tag);
         finish_run();
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wa = 3'(a); wd = 16'(d);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 1; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "room", int'(st_room), 1);
      chk("R1", "idle", int'(st_idle), 1);
      chk("R1", "done", int'(st_done), 0);
      chk("R1", "ovf", int'(st_ovf), 0);
      chk("R1", "irq", int'(irq), 0);
      chk("R1", "ien", int'(st_ien), 0);
      chk("R1", "tx_valid", int'(tx_valid), 0);
      chk("R1", "mem_rd_en", int'(mem_rd_en), 0);
      started = 1'b1;

      // R2 and R10: single frame through the offsets
      cur_tag = "R2 R10 single";
      wr(A_CTRL, 1); wr(A_QADDR, 16'h0010); wr(A_QLEN, 5); idle(10);
      chk("R10", "idle after frame", int'(st_idle), 1);
      chk("R2", "done after frame", int'(st_done), 1);

      // R3: third commit while both slots stay full
      cur_tag = "R3 overflow";
      wr(A_QADDR, 16'h0040); wr(A_QLEN, 8);
      wr(A_QADDR, 16'h0080); wr(A_QLEN, 3);
      wr(A_QADDR, 16'h00C0); wr(A_QLEN, 2);
      idle(20);
      chk("R3", "ovf set", int'(st_ovf), 1);
      chk("R5", "idle after drain", int'(st_idle), 1);
      cur_tag = "R8 clear ovf";
      wr(A_STAT, 2); idle(2);
      chk("R8", "ovf cleared", int'(st_ovf), 0);

      // R3/R4: commit lands on the retiring read of the running frame
      cur_tag = "R3 R4 coincide";
      wr(A_QADDR, 16'h0100); wr(A_QLEN, 3);
      wr(A_QADDR, 16'h0200); wr(A_QLEN, 2);
      wr(A_QLEN, 2);
      idle(15);
      chk("R3", "no ovf on retire", int'(st_ovf), 0);
      chk("R4", "idle after chain", int'(st_idle), 1);

      // R6: zero length
      cur_tag = "R6 zero";
      wr(A_QLEN, 0); idle(3);
      chk("R6", "idle", int'(st_idle), 1);
      chk("R6", "no read", int'(mem_rd_en), 0);
      chk("R6", "ovf", int'(st_ovf), 0);

      // R7: interrupt enable and disable
      cur_tag = "R7 irq";
      irq_cnt = 0;
      wr(A_IEN, 1); wr(A_QADDR, 16'h0300); wr(A_QLEN, 1); idle(4);
      chk("R7", "irq pulses", irq_cnt, 1);
      wr(A_IDIS, 1); wr(A_QLEN, 1); idle(4);
      chk("R7", "irq masked", irq_cnt, 1);
      chk("R7", "ien clear", int'(st_ien), 0);

      // R8: clear coincides with a new completion
      cur_tag = "R8 set wins";
      wr(A_STAT, 1); idle(1);
      chk("R8", "done cleared", int'(st_done), 0);
      wr(A_QLEN, 2); idle(2); wr(A_STAT, 1); idle(2);
      chk("R8", "set wins", int'(st_done), 1);

      // R9: disable discards and ignores
      cur_tag = "R9 disable";
      wr(A_QADDR, 16'h0400); wr(A_QLEN, 20); wr(A_QLEN, 5); idle(3);
      wr(A_CTRL, 0); wr(A_QLEN, 4); idle(5);
      chk("R9", "idle", int'(st_idle), 1);
      chk("R9", "room", int'(st_room), 1);
      chk("R9", "no read", int'(mem_rd_en), 0);
      wr(A_CTRL, 1); idle(3);
      chk("R9", "nothing resumes", int'(st_idle), 1);

      idle(2);
      finish_run();
   end
endmodule